// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is an I2C target that keeps a 5-bit configuration word and drives a small output stage from it. SCL and SDA are sampled by a fast system clock through synchronizers. START and STOP are detected from the sampled lines, and the block answers one fixed 7-bit address. A read returns the stored word. A write may supply several data bytes, but the block keeps only the first one whose top three bits are clear. That byte is committed at the next STOP, and only if write-protect was low when the byte's acknowledge clock fell. After a commit the block ignores its address for a programmable number of cycles. This models the write time of a slow storage cell.

The output stage has two parts. Four outputs choose between the stored bits and four external inputs. A fifth output shows the stored top bit while the select input is low. It freezes its last value when select rises and keeps it while select stays high. An override input forces the register-driven outputs low while select is low.

Top module: `i2c_cfg5_slave`

## Requirements
- R1: After reset the stored word is 5'b00000, sdaOe is low, and with selExt and overrideIn low both muxOut and holdOut are 0.
- R2: An address byte whose upper seven bits equal DEV_ADDR (default 7'b1001110), sent MSB first, is acknowledged by driving sdaOe during the ninth clock. Any other address, including the general call address 7'b0000000, gets no acknowledge.
- R3: When the R/W bit (bit 0 of the address byte) is 1, the slave sends {3'b000, word[4:0]} MSB first. Bit 4 is the hold bit and bits 3..0 feed muxOut[3..0].
- R4: A written data byte with any of bits 7:5 set is acknowledged but never stored.
- R5: Only the first data byte with bits 7:5 all zero is kept. Every later byte in the same transaction gets no acknowledge and has no effect.
- R6: The kept byte reaches the register only at STOP. The register is unchanged before the STOP, and a repeated START discards the kept byte.
- R7: wrProtect is sampled at the SCL fall that ends the acknowledge of the kept byte. If it is high there, the STOP writes nothing, whatever its level at the STOP.
- R8: For BUSY_CYCLES clock cycles after a commit, the device address gets no acknowledge. A transaction that commits nothing starts no busy interval.
- R9: With selExt high, muxOut equals extIn.
- R10: With selExt low and overrideIn high, muxOut and holdOut are 0.
- R11: holdOut keeps the value it had just before selExt rose, for as long as selExt stays high, even if the register or overrideIn changes.
- R12: After a read byte, a NACK from the master ends the transfer. The slave leaves SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | High pulls SDA low (open-drain enable) |
| wrProtect | input | 1 | High blocks the pending write |
| selExt | input | 1 | High selects extIn onto muxOut and freezes holdOut |
| overrideIn | input | 1 | High forces register-driven outputs low |
| extIn | input | 4 | External inputs for the 2-to-1 selection |
| muxOut | output | 4 | Selected four-bit output |
| holdOut | output | 1 | Stored top bit, or its frozen copy while selExt is high |

## Verification
The bench builds the block with BUSY_CYCLES set to 400 and leaves the other parameters at their defaults. With that value, an address byte that starts right after a committing STOP falls inside the busy window and is refused. A wait of a few hundred cycles then ends the window, so both sides of R8 are checked in one short run. The default address and two-stage synchronizers keep the bit-level timing of the bench, which uses six clocks per quarter SCL period, representative of the real configuration.

// File: rtl/cfg5_pkg.sv
package cfg5_pkg;
  localparam int REG_W  = 5;
  localparam int MUX_W  = 4;
  localparam int BYTE_W = 8;

  // strobe from the bus control to the datapath
  typedef struct packed {
    logic             commit;
    logic [REG_W-1:0] data;
  } cfg_wr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_SKIP
  } bus_st_t;
endpackage

// File: rtl/cfg5_sync.sv
module cfg5_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/cfg5_ctrl.sv
module cfg5_ctrl
  import cfg5_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1001110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclS,
  input  logic             sdaS,
  input  logic             wrProtect,
  input  logic             busy,
  input  logic [REG_W-1:0] regVal,
  output logic             sdaOe,
  output cfg_wr_t          wrReq
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int PAD_W = BYTE_W - REG_W;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  bus_st_t          state;
  logic             sclP, sdaP;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftQ, txQ;
  logic             rwQ, validQ, nackQ;
  logic             capQ, wpQ;
  logic [REG_W-1:0] capData;

  logic sclRise, sclFall, startDet, stopDet, addrHit;
  logic [BYTE_W-1:0] txWord;

  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign addrHit  = (shiftQ[BYTE_W-1:1] == DEV_ADDR) && (shiftQ[BYTE_W-1:1] != 7'd0);
  assign txWord   = {{PAD_W{1'b0}}, regVal};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
      bitCnt  <= '0;
      shiftQ  <= '0;
      txQ     <= '0;
      rwQ     <= 1'b0;
      validQ  <= 1'b0;
      nackQ   <= 1'b0;
      capQ    <= 1'b0;
      wpQ     <= 1'b0;
      capData <= '0;
      sdaOe   <= 1'b0;
      wrReq   <= '0;
    end else begin
      sclP         <= sclS;
      sdaP         <= sdaS;
      wrReq.commit <= 1'b0;
      if (stopDet) begin
        state  <= ST_IDLE;
        sdaOe  <= 1'b0;
        bitCnt <= '0;
        capQ   <= 1'b0;
        if (capQ && !wpQ) begin
          wrReq.commit <= 1'b1;
          wrReq.data   <= capData;
        end
      end else if (startDet) begin
        state  <= ST_ADDR;
        sdaOe  <= 1'b0;
        bitCnt <= '0;
        capQ   <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WDATA: begin
            if (sclRise) begin
              shiftQ <= {shiftQ[BYTE_W-2:0], sdaS};
              bitCnt <= bitCnt + CNT_W'(1);
            end else if (sclFall && bitCnt == LAST_BIT) begin
              bitCnt <= '0;
              if (state == ST_WDATA) begin
                state  <= ST_WACK;
                sdaOe  <= 1'b1;
                validQ <= (shiftQ[BYTE_W-1:REG_W] == '0);
              end else if (addrHit && !busy) begin
                state <= ST_AACK;
                sdaOe <= 1'b1;
                rwQ   <= shiftQ[0];
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (sclFall) begin
              if (rwQ) begin
                state <= ST_RDATA;
                txQ   <= txWord;
                sdaOe <= ~txWord[BYTE_W-1];
              end else begin
                state <= ST_WDATA;
                sdaOe <= 1'b0;
              end
            end
          end
          ST_WACK: begin
            if (sclFall) begin
              sdaOe <= 1'b0;
              if (validQ) begin
                capQ    <= 1'b1;
                capData <= shiftQ[REG_W-1:0];
                wpQ     <= wrProtect;
                state   <= ST_SKIP;
              end else begin
                state <= ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (sclRise) begin
              bitCnt <= bitCnt + CNT_W'(1);
            end else if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                state  <= ST_RACK;
                sdaOe  <= 1'b0;
                bitCnt <= '0;
              end else begin
                sdaOe <= ~txQ[BYTE_W-2];
                txQ   <= {txQ[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (sclRise) begin
              nackQ <= sdaS;
            end else if (sclFall) begin
              if (nackQ) begin
                state <= ST_SKIP;
              end else begin
                state <= ST_RDATA;
                txQ   <= txWord;
                sdaOe <= ~txWord[BYTE_W-1];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the line is only pulled while acknowledging or sending read data
  assert_oe_in_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sdaOe |-> (state inside {ST_AACK, ST_WACK, ST_RDATA}));

  // R8: an address that completes during the busy window is not acknowledged
  assert_busy_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && sclFall && bitCnt == LAST_BIT && busy && !startDet && !stopDet) |=> !sdaOe);

  // R6: a commit strobe only follows a detected STOP
  assert_commit_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrReq.commit |-> $past(stopDet));

  // R5, R12: once skipping, the slave keeps the line released
  assert_skip_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sdaOe);
endmodule

// File: rtl/cfg5_dp.sv
module cfg5_dp
  import cfg5_pkg::*;
#(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_wr_t          wrReq,
  input  logic             selExt,
  input  logic             overrideIn,
  input  logic [MUX_W-1:0] extIn,
  output logic [REG_W-1:0] regVal,
  output logic             busy,
  output logic [MUX_W-1:0] muxOut,
  output logic             holdOut
);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [BUSY_W-1:0] BUSY_LD = BUSY_W'(BUSY_CYCLES);

  logic [REG_W-1:0]  regQ;
  logic [BUSY_W-1:0] busyCnt;
  logic              holdQ, liveHold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regQ    <= '0;
      busyCnt <= '0;
    end else if (wrReq.commit) begin
      regQ    <= wrReq.data;
      busyCnt <= BUSY_LD;
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - BUSY_W'(1);
    end
  end

  assign regVal   = regQ;
  assign busy     = (busyCnt != '0);
  assign liveHold = regQ[REG_W-1] & ~overrideIn;

  // hold stage: tracks the live bit while select is low, frozen otherwise
  always_ff @(posedge clk) begin
    if (!rst_n)       holdQ <= 1'b0;
    else if (!selExt) holdQ <= liveHold;
  end
  assign holdOut = selExt ? holdQ : liveHold;

  for (genvar i = 0; i < MUX_W; i++) begin : g_mux
    assign muxOut[i] = selExt ? extIn[i] : (regQ[i] & ~overrideIn);
  end

  // R6: the stored word changes only on a commit strobe
  assert_reg_on_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wrReq.commit) |-> $stable(regQ));

  // R8: a commit always opens a busy window
  assert_busy_after_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrReq.commit) |-> busy);

  // R11: the held bit does not move while select stays high
  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (selExt && $past(selExt)) |-> $stable(holdOut));
endmodule

// File: rtl/i2c_cfg5_slave.sv
module i2c_cfg5_slave
  import cfg5_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1001110,
  parameter int         BUSY_CYCLES = 500000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  input  logic             wrProtect,
  input  logic             selExt,
  input  logic             overrideIn,
  input  logic [MUX_W-1:0] extIn,
  output logic [MUX_W-1:0] muxOut,
  output logic             holdOut
);
  logic [1:0]       lineS;
  logic             busy;
  logic [REG_W-1:0] regVal;
  cfg_wr_t          wrReq;

  cfg5_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclIn, sdaIn}), .q(lineS)
  );

  cfg5_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclS(lineS[1]), .sdaS(lineS[0]),
    .wrProtect(wrProtect), .busy(busy), .regVal(regVal),
    .sdaOe(sdaOe), .wrReq(wrReq)
  );

  cfg5_dp #(.BUSY_CYCLES(BUSY_CYCLES)) u_dp (
    .clk(clk), .rst_n(rst_n), .wrReq(wrReq), .selExt(selExt),
    .overrideIn(overrideIn), .extIn(extIn), .regVal(regVal), .busy(busy),
    .muxOut(muxOut), .holdOut(holdOut)
  );
endmodule

// File: tb/i2c_cfg5_slave_test.sv
module i2c_cfg5_slave_test;
  localparam int BUSY = 400;
  localparam int Q    = 6;
  localparam logic [6:0] ADR = 7'b1001110;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, scl, sdaM, wp, sel, ovr;
  logic [3:0] ext, muxOut;
  logic sdaOe, holdOut, sdaBus;
  assign sdaBus = sdaM & ~sdaOe;

  i2c_cfg5_slave #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .sclIn(scl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .wrProtect(wp), .selExt(sel), .overrideIn(ovr), .extIn(ext),
    .muxOut(muxOut), .holdOut(holdOut)
  );

  int nVec = 0, nBad = 0;
  string      reqQ[$];
  logic [7:0] expQ[$];
  logic [7:0] actQ[$];
  event obsEv;

  task automatic drain();
    while (actQ.size() > 0 && expQ.size() > 0) begin
      string r = reqQ.pop_front();
      logic [7:0] e = expQ.pop_front();
      logic [7:0] a = actQ.pop_front();
      nVec++;
      if (a !== e) begin
        nBad++;
        $display("FAIL %s actual=%0h expected=%0h", r, a, e);
      end
    end
  endtask

  // monitor: compares observations with the expected items as they arrive
  initial forever begin
    @(obsEv);
    drain();
  end

  task automatic expectVal(string r, logic [7:0] v);
    reqQ.push_back(r);
    expQ.push_back(v);
  endtask
  task automatic observe(logic [7:0] v);
    actQ.push_back(v);
    -> obsEv;
  endtask
  task automatic chk(string r, logic [7:0] e, logic [7:0] a);
    expectVal(r, e);
    observe(a);
  endtask

  task automatic tick(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask
  task automatic i2cStart();
    sdaM = 1'b1; tick(); scl = 1'b1; tick(); sdaM = 1'b0; tick(); scl = 1'b0; tick();
  endtask
  task automatic i2cStop();
    sdaM = 1'b0; tick(); scl = 1'b1; tick(); sdaM = 1'b1; tick();
  endtask
  task automatic wbit(logic b);
    sdaM = b; tick(); scl = 1'b1; tick(2); scl = 1'b0; tick();
  endtask
  task automatic rbit(output logic b);
    sdaM = 1'b1; tick(); scl = 1'b1; tick(); b = sdaBus; tick(); scl = 1'b0; tick();
  endtask
  task automatic wbyte(logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask
  task automatic rbyte(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(nack);
  endtask
  task automatic addr(logic [6:0] a, logic rw, output logic ack);
    i2cStart();
    wbyte({a, rw}, ack);
  endtask
  task automatic waitBusy();
    repeat (BUSY + 40) @(negedge clk);
  endtask
  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rd;
    rst_n = 1'b0; scl = 1'b1; sdaM = 1'b1; wp = 1'b0; sel = 1'b0; ovr = 1'b0; ext = 4'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 muxOut", 8'h00, {4'h0, muxOut});
    chk("R1 holdOut", 8'h00, {7'h0, holdOut});
    chk("R1 sdaOe", 8'h00, {7'h0, sdaOe});
    addr(ADR, 1'b1, ack);
    chk("R2 addr ack read", 8'h01, {7'h0, ack});
    rbyte(rd, 1'b1); i2cStop();
    chk("R1 R3 reset word read", 8'h00, rd);

    // write 0x15, commit at stop
    addr(ADR, 1'b0, ack);
    chk("R2 addr ack write", 8'h01, {7'h0, ack});
    wbyte(8'h15, ack);
    chk("R4 valid byte ack", 8'h01, {7'h0, ack});
    chk("R6 no change before stop", 8'h00, {4'h0, muxOut});
    i2cStop();
    chk("R6 muxOut after stop", 8'h05, {4'h0, muxOut});
    chk("R6 holdOut after stop", 8'h01, {7'h0, holdOut});
    addr(ADR, 1'b1, ack); i2cStop();
    chk("R8 busy addr nack", 8'h00, {7'h0, ack});
    waitBusy();
    addr(ADR, 1'b1, ack);
    chk("R8 ack after busy", 8'h01, {7'h0, ack});
    rbyte(rd, 1'b1);
    chk("R3 read word", 8'h15, rd);
    rbyte(rd, 1'b1); i2cStop();
    chk("R12 released after nack", 8'hFF, rd);

    // R2 wrong address and general call
    addr(7'b1001111, 1'b0, ack); i2cStop();
    chk("R2 other addr nack", 8'h00, {7'h0, ack});
    addr(7'b0000000, 1'b0, ack); i2cStop();
    chk("R2 general call nack", 8'h00, {7'h0, ack});

    // R4 invalid byte
    addr(ADR, 1'b0, ack); wbyte(8'hE3, ack); i2cStop();
    chk("R4 invalid byte ack", 8'h01, {7'h0, ack});
    chk("R4 invalid not stored", 8'h05, {4'h0, muxOut});

    // R5 invalid then valid then extra
    addr(ADR, 1'b0, ack); wbyte(8'h2A, ack);
    chk("R5 first invalid ack", 8'h01, {7'h0, ack});
    wbyte(8'h0A, ack);
    chk("R5 valid ack", 8'h01, {7'h0, ack});
    wbyte(8'h1F, ack);
    chk("R5 extra byte nack", 8'h00, {7'h0, ack});
    i2cStop();
    chk("R5 first valid kept", 8'h0A, {4'h0, muxOut});
    chk("R5 hold bit of kept", 8'h00, {7'h0, holdOut});
    waitBusy();

    // R7 write protect at ack
    wp = 1'b1;
    addr(ADR, 1'b0, ack); wbyte(8'h1F, ack);
    wp = 1'b0; i2cStop();
    chk("R7 protected no write", 8'h0A, {4'h0, muxOut});
    addr(ADR, 1'b1, ack); rbyte(rd, 1'b1); i2cStop();
    chk("R8 no busy without commit", 8'h01, {7'h0, ack});
    addr(ADR, 1'b0, ack); wbyte(8'h03, ack);
    wp = 1'b1; i2cStop();
    chk("R7 late wp ignored", 8'h03, {4'h0, muxOut});
    wp = 1'b0;
    waitBusy();

    // R6 repeated start discards
    addr(ADR, 1'b0, ack); wbyte(8'h0C, ack);
    addr(ADR, 1'b1, ack); rbyte(rd, 1'b1); i2cStop();
    chk("R6 restart discards read", 8'h03, rd);
    chk("R6 restart discards out", 8'h03, {4'h0, muxOut});

    // R9 external selection, R10 override
    sel = 1'b1; ext = 4'h9; tick();
    chk("R9 ext 9", 8'h09, {4'h0, muxOut});
    ext = 4'h4; tick();
    chk("R9 ext 4", 8'h04, {4'h0, muxOut});
    sel = 1'b0; ovr = 1'b1; tick();
    chk("R10 override mux", 8'h00, {4'h0, muxOut});
    ovr = 1'b0; tick();

    // R11 hold latch
    addr(ADR, 1'b0, ack); wbyte(8'h10, ack); i2cStop();
    waitBusy();
    chk("R11 live hold bit", 8'h01, {7'h0, holdOut});
    ovr = 1'b1; tick();
    chk("R10 override hold", 8'h00, {7'h0, holdOut});
    ovr = 1'b0; tick();
    sel = 1'b1; ext = 4'h6; tick();
    chk("R11 hold after rise", 8'h01, {7'h0, holdOut});
    ovr = 1'b1; tick();
    chk("R11 hold ignores override", 8'h01, {7'h0, holdOut});
    ovr = 1'b0;
    addr(ADR, 1'b0, ack); wbyte(8'h00, ack); i2cStop();
    chk("R11 hold ignores commit", 8'h01, {7'h0, holdOut});
    chk("R9 mux under commit", 8'h06, {4'h0, muxOut});
    sel = 1'b0; tick();
    chk("R11 live after fall", 8'h00, {7'h0, holdOut});

    tick(2);
    drain();
    summary();
    $finish;
  end
endmodule